// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides how a 32-bit core enters and leaves two exceptions: the system reset interrupt and the machine check. Each cycle it samples a reset-interrupt request, a bus error indication from the address or data phase, and a return-from-interrupt request. It also receives the current machine state register, the current and next instruction addresses, the live SRR0/SRR1 contents, a boot configuration bit and a debug-enable flag. One clock later it presents write strobes and new values for SRR0, SRR1 and the machine state register, together with a fetch redirect and its target address.

When machine checks are disabled in the machine state register, a bus error is not taken. If debug entry is enabled, the block raises a one-cycle debug-entry pulse. Otherwise it latches a checkstop indication. That indication halts all further exception handling until the core reset is applied, and the system can use it to trigger an automatic reset.

Bit numbering follows the convention where bit 0 is the most significant bit. Bit k of a register is therefore vector index 31-k.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A reset request redirects fetch one cycle later to 0x00000100 when iip_i is 1 and to 0xFFF00100 when iip_i is 0.
- R2: On any interrupt entry, srr1_o equals msr_i with bits 1..4 (index 30:27) and bits 10..15 (index 21:16) forced to zero. All other bits, including the recoverable bit 30 (index 1), keep their position.
- R3: On interrupt entry, msr_o keeps IP (bit 25, index 6) and ME (bit 19, index 12), takes LE (bit 31, index 0) from ILE (bit 15, index 16), and clears every other bit.
- R4: srr0_o captures next_pc_i for a reset interrupt and cur_pc_i for a machine check.
- R5: A bus error with ME=1 is taken with fetch at base+0x200, where the base is 0x00000000 when iip_i is 1 and 0xFFF00000 when it is 0. mc_recov_o equals the RI bit of msr_i.
- R6: A bus error with ME=0 and dbg_en_i=0 sets checkstop_o. It stays set until rst_ni, and while it is set every request is ignored, with no strobe or redirect.
- R7: A bus error with ME=0 and dbg_en_i=1 gives a one-cycle debug_entry_o pulse with no strobe, no redirect and no checkstop.
- R8: Return-from-interrupt sets msr_o to MSR bits 0..15 from msr_i and bits 16..31 from srr1_i, redirects fetch to srr0_i, and leaves srr_we_o low.
- R9: Priority is reset request over bus error over return-from-interrupt.
- R10: After rst_ni every output is zero, and in cycles with no request all strobes, redirect and debug_entry_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous core reset |
| reset_req_i | input | 1 | System reset interrupt request |
| bus_err_i | input | 1 | Bus error response (machine check source) |
| rfi_i | input | 1 | Return-from-interrupt request |
| msr_i | input | 32 | Current machine state register |
| srr0_i | input | 32 | Current SRR0 (return address) |
| srr1_i | input | 32 | Current SRR1 (saved state) |
| cur_pc_i | input | 32 | Address of the current instruction |
| next_pc_i | input | 32 | Address of the next instruction |
| iip_i | input | 1 | Boot configuration: 1 selects low vector base |
| dbg_en_i | input | 1 | Debug entry enabled |
| srr_we_o | output | 1 | Write strobe for SRR0 and SRR1 |
| srr0_o | output | 32 | New SRR0 value |
| srr1_o | output | 32 | New SRR1 value |
| msr_we_o | output | 1 | Write strobe for machine state register |
| msr_o | output | 32 | New machine state register value |
| redirect_o | output | 1 | Fetch redirect strobe |
| fetch_addr_o | output | 32 | Redirect target address |
| mc_recov_o | output | 1 | Taken machine check is recoverable |
| checkstop_o | output | 1 | Checkstop state, request for system reset |
| debug_entry_o | output | 1 | One-cycle debug entry pulse |

## Verification
The main function is exercised with reset requests under both boot bit values, so that the two vector bases are told apart. Machine checks are applied with RI set and clear and with ILE set, which separates the same-position SRR1 copy from the LE-from-ILE rule. A return-from-interrupt case uses an SRR1 whose halves differ from the MSR, which shows which half is restored. Combined requests in one cycle separate the three priority levels. Directed cases with ME cleared separate the debug path from checkstop, and confirm that a checkstop swallows a later reset request until rst_ni.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;

  // vector index of MSB-first bit k is XLEN-1-k
  localparam int MSR_LE  = 0;   // bit 31
  localparam int MSR_RI  = 1;   // bit 30
  localparam int MSR_IP  = 6;   // bit 25
  localparam int MSR_ME  = 12;  // bit 19
  localparam int MSR_ILE = 16;  // bit 15

  localparam int CLR_A_HI = 30;  // bits 1..4
  localparam int CLR_A_LO = 27;
  localparam int CLR_B_HI = 21;  // bits 10..15
  localparam int CLR_B_LO = 16;

  localparam int HALF = XLEN / 2;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_RST,
    EV_MC_TAKE,
    EV_MC_DBG,
    EV_MC_STOP,
    EV_RFI
  } exc_ev_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic    stopped_i,
  input  logic    reset_req_i,
  input  logic    bus_err_i,
  input  logic    rfi_i,
  input  logic    me_i,
  input  logic    dbg_en_i,
  output exc_ev_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (stopped_i)        ev_o = EV_NONE;
    else if (reset_req_i) ev_o = EV_RST;
    else if (bus_err_i) begin
      if (me_i)           ev_o = EV_MC_TAKE;
      else if (dbg_en_i)  ev_o = EV_MC_DBG;
      else                ev_o = EV_MC_STOP;
    end
    else if (rfi_i)       ev_o = EV_RFI;
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] srr1_i,
  output logic [XLEN-1:0] save_srr1_o,
  output logic [XLEN-1:0] entry_msr_o,
  output logic [XLEN-1:0] rfi_msr_o
);
  logic [HALF-1:0] unused_srr1_hi;
  assign unused_srr1_hi = srr1_i[XLEN-1:HALF];

  always_comb begin
    save_srr1_o = msr_i;
    save_srr1_o[CLR_A_HI:CLR_A_LO] = '0;
    save_srr1_o[CLR_B_HI:CLR_B_LO] = '0;
  end

  always_comb begin
    entry_msr_o         = '0;
    entry_msr_o[MSR_IP] = msr_i[MSR_IP];
    entry_msr_o[MSR_ME] = msr_i[MSR_ME];
    entry_msr_o[MSR_LE] = msr_i[MSR_ILE];
  end

  // MSB-first bits 16..31 are the low vector half
  assign rfi_msr_o = {msr_i[XLEN-1:HALF], srr1_i[HALF-1:0]};
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFF0_0000,
  parameter logic [XLEN-1:0] RST_OFF = 32'h0000_0100,
  parameter logic [XLEN-1:0] MC_OFF  = 32'h0000_0200
) (
  input  logic            iip_i,
  input  logic            is_mc_i,
  output logic [XLEN-1:0] vec_o
);
  logic [XLEN-1:0] base;
  assign base  = iip_i ? '0 : HI_BASE;
  assign vec_o = base + (is_mc_i ? MC_OFF : RST_OFF);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] RST_OFF = 32'h0000_0100,
  parameter logic [31:0] MC_OFF  = 32'h0000_0200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reset_req_i,
  input  logic        bus_err_i,
  input  logic        rfi_i,
  input  logic [31:0] msr_i,
  input  logic [31:0] srr0_i,
  input  logic [31:0] srr1_i,
  input  logic [31:0] cur_pc_i,
  input  logic [31:0] next_pc_i,
  input  logic        iip_i,
  input  logic        dbg_en_i,
  output logic        srr_we_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic        msr_we_o,
  output logic [31:0] msr_o,
  output logic        redirect_o,
  output logic [31:0] fetch_addr_o,
  output logic        mc_recov_o,
  output logic        checkstop_o,
  output logic        debug_entry_o
);
  exc_ev_e         ev;
  logic [XLEN-1:0] save_srr1, entry_msr, rfi_msr, vec;
  logic            is_int;

  exc_arbiter u_arb (
    .stopped_i  (checkstop_o),
    .reset_req_i(reset_req_i),
    .bus_err_i  (bus_err_i),
    .rfi_i      (rfi_i),
    .me_i       (msr_i[MSR_ME]),
    .dbg_en_i   (dbg_en_i),
    .ev_o       (ev)
  );

  exc_state_calc u_calc (
    .msr_i      (msr_i),
    .srr1_i     (srr1_i),
    .save_srr1_o(save_srr1),
    .entry_msr_o(entry_msr),
    .rfi_msr_o  (rfi_msr)
  );

  exc_vector_sel #(
    .HI_BASE(HI_BASE),
    .RST_OFF(RST_OFF),
    .MC_OFF (MC_OFF)
  ) u_vec (
    .iip_i  (iip_i),
    .is_mc_i(ev == EV_MC_TAKE),
    .vec_o  (vec)
  );

  assign is_int = (ev == EV_RST) || (ev == EV_MC_TAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr_we_o      <= 1'b0;
      srr0_o        <= '0;
      srr1_o        <= '0;
      msr_we_o      <= 1'b0;
      msr_o         <= '0;
      redirect_o    <= 1'b0;
      fetch_addr_o  <= '0;
      mc_recov_o    <= 1'b0;
      checkstop_o   <= 1'b0;
      debug_entry_o <= 1'b0;
    end else begin
      srr_we_o      <= is_int;
      msr_we_o      <= is_int || (ev == EV_RFI);
      redirect_o    <= is_int || (ev == EV_RFI);
      mc_recov_o    <= (ev == EV_MC_TAKE) && msr_i[MSR_RI];
      debug_entry_o <= (ev == EV_MC_DBG);
      checkstop_o   <= checkstop_o || (ev == EV_MC_STOP);
      if (is_int) begin
        srr0_o       <= (ev == EV_RST) ? next_pc_i : cur_pc_i;
        srr1_o       <= save_srr1;
        msr_o        <= entry_msr;
        fetch_addr_o <= vec;
      end else if (ev == EV_RFI) begin
        msr_o        <= rfi_msr;
        fetch_addr_o <= srr0_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reset_req_i,
  input logic        bus_err_i,
  input logic        rfi_i,
  input logic [31:0] msr_i,
  input logic [31:0] srr0_i,
  input logic [31:0] srr1_i,
  input logic [31:0] cur_pc_i,
  input logic [31:0] next_pc_i,
  input logic        iip_i,
  input logic        dbg_en_i,
  input logic        srr_we_o,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o,
  input logic        msr_we_o,
  input logic [31:0] msr_o,
  input logic        redirect_o,
  input logic [31:0] fetch_addr_o,
  input logic        mc_recov_o,
  input logic        checkstop_o,
  input logic        debug_entry_o
);
  a_r6_checkstop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> checkstop_o);

  a_r6_silent_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> !(srr_we_o || msr_we_o || redirect_o || debug_entry_o));

  a_r2_srr1_cleared_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srr_we_o |-> (srr1_o[30:27] == 4'h0 && srr1_o[21:16] == 6'h0));

  a_r1_reset_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_req_i && !checkstop_o) |=>
      (redirect_o && srr_we_o &&
       fetch_addr_o == ($past(iip_i) ? 32'h0000_0100 : 32'hFFF0_0100)));

  a_r8_rfi_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !reset_req_i && !bus_err_i && !checkstop_o) |=>
      (redirect_o && !srr_we_o && fetch_addr_o == $past(srr0_i)));

  a_r7_debug_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_entry_o |-> !(redirect_o || srr_we_o || msr_we_o));

  a_r5_recov_only_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_recov_o |-> srr_we_o);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reset_req_i = 0, bus_err_i = 0, rfi_i = 0, iip_i = 0, dbg_en_i = 0;
  logic [31:0] msr_i = 0;
  logic [31:0] srr0_i = 32'h2000_0010;
  logic [31:0] srr1_i = 32'hA5A5_5A5A;
  logic [31:0] cur_pc_i = 32'h1000_0040;
  logic [31:0] next_pc_i = 32'h1000_0044;
  logic        srr_we_o, msr_we_o, redirect_o, mc_recov_o, checkstop_o, debug_entry_o;
  logic [31:0] srr0_o, srr1_o, msr_o, fetch_addr_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  exc_entry_ctrl u_dut (.clk_i(clk), .*);

  // kind: 0 none, 1 reset, 2 machine check taken, 3 rfi
  typedef struct packed {
    logic        rq, be, rf, iip;
    logic [31:0] msr;
    logic [1:0]  kind;
    logic [31:0] fetch;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd1, 32'h0000_0100},
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd1, 32'hFFF0_0100},
    '{1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_1002, 2'd2, 32'h0000_0200},
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'h7801_1040, 2'd2, 32'hFFF0_0200},
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_8765, 2'd3, 32'h2000_0010},
    '{1'b1, 1'b1, 1'b1, 1'b1, 32'h0001_1000, 2'd1, 32'h0000_0100},
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_1000, 2'd2, 32'h0000_0200},
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 2'd0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_srr1(input logic [31:0] m);
    logic [31:0] s = m;
    s[30:27] = '0;
    s[21:16] = '0;
    return s;
  endfunction

  function automatic logic [31:0] m_msr(input logic [31:0] m);
    logic [31:0] r = '0;
    r[6] = m[6]; r[12] = m[12]; r[0] = m[16];
    return r;
  endfunction

  task automatic clr_in();
    reset_req_i = 0; bus_err_i = 0; rfi_i = 0;
  endtask

  initial begin
    #200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 reset strobes", {28'b0, srr_we_o, msr_we_o, redirect_o, debug_entry_o}, 32'h0);
    chk("R10 reset checkstop", {31'b0, checkstop_o}, 32'h0);
    chk("R10 reset fetch", fetch_addr_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      reset_req_i = VT[i].rq; bus_err_i = VT[i].be; rfi_i = VT[i].rf;
      iip_i = VT[i].iip; msr_i = VT[i].msr; dbg_en_i = 1'b0;
      @(negedge clk);
      clr_in();
      case (VT[i].kind)
        2'd0: chk("R10 idle strobes", {29'b0, srr_we_o, msr_we_o, redirect_o}, 32'h0);
        2'd3: begin
          chk("R8 rfi strobes", {29'b0, srr_we_o, msr_we_o, redirect_o}, 32'h3);
          chk("R8 rfi msr", msr_o, {VT[i].msr[31:16], srr1_i[15:0]});
          chk("R8 rfi fetch", fetch_addr_o, VT[i].fetch);
        end
        default: begin
          chk("R9 interrupt strobes", {29'b0, srr_we_o, msr_we_o, redirect_o}, 32'h7);
          chk(VT[i].kind == 2'd1 ? "R1 reset fetch" : "R5 mc fetch", fetch_addr_o, VT[i].fetch);
          chk("R2 srr1 save", srr1_o, m_srr1(VT[i].msr));
          chk("R3 entry msr", msr_o, m_msr(VT[i].msr));
          chk("R4 srr0", srr0_o, VT[i].kind == 2'd1 ? next_pc_i : cur_pc_i);
          chk("R5 recoverable", {31'b0, mc_recov_o},
              {31'b0, VT[i].kind == 2'd2 && VT[i].msr[1]});
        end
      endcase
      @(negedge clk);
      chk("R10 strobes drop", {29'b0, srr_we_o, msr_we_o, redirect_o}, 32'h0);
    end

    // R7 debug entry
    msr_i = 32'h0000_0002; dbg_en_i = 1'b1; bus_err_i = 1'b1;
    @(negedge clk);
    clr_in();
    chk("R7 debug pulse", {31'b0, debug_entry_o}, 32'h1);
    chk("R7 no redirect", {30'b0, redirect_o, checkstop_o}, 32'h0);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, debug_entry_o}, 32'h0);

    // R6 checkstop
    dbg_en_i = 1'b0; bus_err_i = 1'b1;
    @(negedge clk);
    clr_in();
    chk("R6 checkstop set", {31'b0, checkstop_o}, 32'h1);
    chk("R6 not taken", {30'b0, redirect_o, srr_we_o}, 32'h0);
    reset_req_i = 1'b1; iip_i = 1'b1;
    @(negedge clk);
    clr_in();
    chk("R6 reset req ignored", {30'b0, redirect_o, srr_we_o}, 32'h0);
    chk("R6 checkstop held", {31'b0, checkstop_o}, 32'h1);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R6 cleared by rst_ni", {31'b0, checkstop_o}, 32'h0);
    reset_req_i = 1'b1;
    @(negedge clk);
    clr_in();
    chk("R1 resumes after rst_ni", fetch_addr_o, 32'h0000_0100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule